// File: doc/BRIEF.md
# Coprocessor Reconfiguration Request Controller

This block decides when a coprocessor must be loaded into one of a small set of reconfigurable regions. It serves a processor that wants to talk to a particular coprocessor. The processor raises a select request with a coprocessor identifier. The block looks the identifier up in an allocation table that records, per region, whether the region holds a coprocessor, which one, and whether the processor has dismissed it.

When the coprocessor is already resident, the block acknowledges on the next clock and starts no transfer. When it is absent, the block does the following in order:
- picks a region to overwrite;
- queues the identifier in a scheduled-bitstream buffer;
- issues a one-cycle start to an external bitstream transfer engine, with the start address and length taken from a per-identifier lookup table that a host fills beforehand;
- waits for the engine to report completion;
- records the new occupant and only then acknowledges.

The handshake is level based. The acknowledge stays high for as long as the request stays high, and it falls one clock after the request falls.

A separate dismiss input marks a resident coprocessor as no longer needed, which makes its region preferred for the next replacement. When choosing which region to overwrite, the block never takes the region in current use. Among the others it prefers an empty region, then a dismissed one, then the one selected longest ago.

Top module: `cop_reload_ctrl`

## Requirements
- R1: After reset `sel_ack` and `xfer_start` are low and every region is empty, so the first select of any identifier is a miss.
- R2: A select whose identifier is resident raises `sel_ack` on the first clock edge that sees the request, with `sel_region` giving the holding region, and no `xfer_start` pulse.
- R3: A select whose identifier is not resident produces a single-cycle `xfer_start` in the cycle after the request is taken, and `xfer_len` holds the length stored for that identifier.
- R4: On a miss, `sel_ack` stays low until `xfer_done` is seen. It rises at the edge that samples `xfer_done`, and then `sel_region` equals the region that was loaded.
- R5: Once high, `sel_ack` remains high while `sel_req` stays high, and it drops at the first edge that sees `sel_req` low.
- R6: The overwritten region is the lowest-numbered empty region, whenever one exists outside the region in current use.
- R7: If no such empty region exists, the lowest-numbered region holding a dismissed coprocessor is overwritten, excluding the region in current use.
- R8: Otherwise the region selected longest ago is overwritten. The region in current use is never overwritten.
- R9: A dismiss whose identifier is not resident leaves the allocation table unchanged.
- R10: A host write to the lookup table for an identifier changes the `xfer_addr` and `xfer_len` issued for later loads of that identifier.
- R11: Selecting a dismissed coprocessor again (a hit) clears its dismissal, so its region loses the dismissed preference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_req | input | 1 | Select request level from the processor |
| sel_id | input | ID_W | Identifier of the requested coprocessor |
| sel_ack | output | 1 | Coprocessor ready; held while `sel_req` is high |
| sel_region | output | RW | Region holding the selected coprocessor |
| dis_req | input | 1 | One-cycle dismiss strobe |
| dis_id | input | ID_W | Identifier being dismissed |
| cfg_wr | input | 1 | Host write strobe for the lookup table |
| cfg_id | input | ID_W | Identifier whose entry is written |
| cfg_addr | input | ADDR_W | Bitstream start address to store |
| cfg_len | input | LEN_W | Bitstream length to store |
| xfer_start | output | 1 | One-cycle start to the transfer engine |
| xfer_region | output | RW | Region to be reconfigured |
| xfer_addr | output | ADDR_W | Bitstream start address for the transfer |
| xfer_len | output | LEN_W | Bitstream length for the transfer |
| xfer_done | input | 1 | Transfer engine completion strobe |

## Verification
The hardest situations to reach from the ports are the replacement choices that depend on history. These include a dismissed region competing against an older undismissed one, a dismissal that a later hit has cleared, and the rule that excludes the region in current use. The bench runs with three regions so that these choices become visible. It first walks directed sequences that fill the regions, dismiss, re-select and then miss, so that each replacement rule decides one load. After that it runs a long pseudo-random mix of selects and dismisses over a few identifiers, with varied transfer latencies. An arithmetic model keeps a last-use stamp and a dismissed flag per region and predicts every hit, every chosen region and every acknowledge cycle.

// File: rtl/cop_pkg.sv
// Shared definitions for the coprocessor reconfiguration controller.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package cop_pkg;

    // Control sequencer states of the request controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } ctl_state_e;

    // Width of a region index for a given region count
    function automatic int region_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cop_bs_lut.sv
// Bitstream lookup table: per coprocessor identifier, a start address and a
// length. Written by a host port, read combinationally by identifier.
// Assumes: the host fills the entries before the first select that needs them.
module cop_bs_lut #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ID_W-1:0]   rd_id,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int ENTRIES = 1 << ID_W;

    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [LEN_W-1:0]  len_q  [ENTRIES];

    // Store host writes; clear all entries on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                addr_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else if (wr_en) begin
            addr_q[wr_id] <= wr_addr;
            len_q[wr_id]  <= wr_len;
        end
    end

    // Combinational read by identifier
    always_comb begin
        rd_addr = addr_q[rd_id];
        rd_len  = len_q[rd_id];
    end
endmodule

// File: rtl/cop_sched_fifo.sv
// Scheduled-bitstream buffer: a small FIFO of coprocessor identifiers that
// are waiting for a transfer. Head is visible combinationally.
// Assumes: DEPTH is a power of two, at least 2; no push when full, no pop when empty.
module cop_sched_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [PW:0]   cnt_q;

    // Write side: store pushed identifier and advance write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else if (push) begin
            mem_q[wr_q] <= push_data;
            wr_q        <= wr_q + 1'b1;
        end
    end

    // Read side: advance read pointer on pop
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else if (pop) rd_q <= rd_q + 1'b1;
    end

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (push && !pop) cnt_q <= cnt_q + 1'b1;
        else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end

    assign head  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (PW+1)'(DEPTH));
endmodule

// File: rtl/cop_alloc_table.sv
// Region allocation table: per region a valid bit, a dismissed bit, the
// resident identifier and a recency rank. Gives the hit lookup and the
// replacement choice (empty, then dismissed, then oldest, never current).
// Assumes: touch_reg and load on the same region are applied together;
// a touch overrides a dismiss of the same region in the same cycle.
module cop_alloc_table #(
    parameter int NUM_REGIONS = 2,
    parameter int ID_W        = 4,
    localparam int RW         = cop_pkg::region_w(NUM_REGIONS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] look_id,
    output logic            hit,
    output logic [RW-1:0]   hit_reg,
    output logic [RW-1:0]   victim_reg,
    input  logic            dis_vld,
    input  logic [ID_W-1:0] dis_id,
    input  logic            touch_vld,
    input  logic [RW-1:0]   touch_reg,
    input  logic            load_vld,
    input  logic [ID_W-1:0] load_id,
    output logic            cur_vld,
    output logic [RW-1:0]   cur_reg
);
    logic [NUM_REGIONS-1:0] vld_q, dis_q, elig;
    logic [ID_W-1:0]        id_q   [NUM_REGIONS];
    logic [RW-1:0]          rank_q [NUM_REGIONS];
    logic                   cur_vld_q;
    logic [RW-1:0]          cur_q;
    logic                   inv_any, dis_any, lru_any;
    logic [RW-1:0]          inv_reg, dis_reg, lru_reg, lru_rank;

    // Hit lookup: lowest region holding the requested identifier
    always_comb begin
        hit     = 1'b0;
        hit_reg = '0;
        for (int j = NUM_REGIONS - 1; j >= 0; j--) begin
            if (vld_q[j] && id_q[j] == look_id) begin
                hit     = 1'b1;
                hit_reg = RW'(j);
            end
        end
    end

    // Regions allowed as replacement: all except the one in current use
    always_comb begin
        for (int j = 0; j < NUM_REGIONS; j++)
            elig[j] = !(cur_vld_q && cur_q == RW'(j));
    end

    // Replacement choice by priority: empty, dismissed, least recent
    always_comb begin
        inv_any  = 1'b0;
        inv_reg  = '0;
        dis_any  = 1'b0;
        dis_reg  = '0;
        lru_any  = 1'b0;
        lru_reg  = '0;
        lru_rank = '0;
        for (int j = NUM_REGIONS - 1; j >= 0; j--) begin
            if (elig[j] && !vld_q[j]) begin
                inv_any = 1'b1;
                inv_reg = RW'(j);
            end
            if (elig[j] && vld_q[j] && dis_q[j]) begin
                dis_any = 1'b1;
                dis_reg = RW'(j);
            end
        end
        for (int j = 0; j < NUM_REGIONS; j++) begin
            if (elig[j] && (!lru_any || rank_q[j] < lru_rank)) begin
                lru_any  = 1'b1;
                lru_reg  = RW'(j);
                lru_rank = rank_q[j];
            end
        end
        if (inv_any)      victim_reg = inv_reg;
        else if (dis_any) victim_reg = dis_reg;
        else              victim_reg = lru_reg;
    end

    // Table contents: dismissal marks, then touch and load updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dis_q <= '0;
            for (int j = 0; j < NUM_REGIONS; j++) id_q[j] <= '0;
        end else begin
            for (int j = 0; j < NUM_REGIONS; j++) begin
                if (dis_vld && vld_q[j] && id_q[j] == dis_id) dis_q[j] <= 1'b1;
                if (touch_vld && touch_reg == RW'(j)) begin
                    dis_q[j] <= 1'b0;
                    if (load_vld) begin
                        vld_q[j] <= 1'b1;
                        id_q[j]  <= load_id;
                    end
                end
            end
        end
    end

    // Recency ranks: touched region becomes newest, newer ones shift down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_REGIONS; j++) rank_q[j] <= RW'(j);
        end else if (touch_vld) begin
            for (int j = 0; j < NUM_REGIONS; j++) begin
                if (touch_reg == RW'(j))
                    rank_q[j] <= RW'(NUM_REGIONS - 1);
                else if (rank_q[j] > rank_q[touch_reg])
                    rank_q[j] <= rank_q[j] - 1'b1;
            end
        end
    end

    // Region in current use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld_q <= 1'b0;
            cur_q     <= '0;
        end else if (touch_vld) begin
            cur_vld_q <= 1'b1;
            cur_q     <= touch_reg;
        end
    end

    assign cur_vld = cur_vld_q;
    assign cur_reg = cur_q;
endmodule

// File: rtl/cop_reload_ctrl.sv
// Coprocessor reconfiguration request controller (top). Accepts a level
// select request, acknowledges at once on a hit, otherwise schedules a load
// through the scheduled-bitstream buffer, drives the transfer engine and
// acknowledges after completion.
// Assumes: sel_req stays high until sel_ack is seen; xfer_done is a single
// cycle strobe that only follows an xfer_start.
module cop_reload_ctrl #(
    parameter int NUM_REGIONS = 2,
    parameter int ID_W        = 4,
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 12,
    parameter int QDEPTH      = 2,
    localparam int RW         = cop_pkg::region_w(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_req,
    input  logic [ID_W-1:0]   sel_id,
    output logic              sel_ack,
    output logic [RW-1:0]     sel_region,
    input  logic              dis_req,
    input  logic [ID_W-1:0]   dis_id,
    input  logic              cfg_wr,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              xfer_start,
    output logic [RW-1:0]     xfer_region,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done
);
    import cop_pkg::*;

    ctl_state_e      state_q;
    logic [RW-1:0]   vic_q;
    logic [ID_W-1:0] pend_q;
    logic            hit, cur_vld;
    logic [RW-1:0]   hit_reg, victim_reg, cur_reg;
    logic            q_push, q_pop, q_empty, q_full;
    logic [ID_W-1:0] q_head;
    logic            touch_vld, load_vld;
    logic [RW-1:0]   touch_reg;

    cop_alloc_table #(.NUM_REGIONS(NUM_REGIONS), .ID_W(ID_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .look_id(sel_id), .hit(hit), .hit_reg(hit_reg), .victim_reg(victim_reg),
        .dis_vld(dis_req), .dis_id(dis_id),
        .touch_vld(touch_vld), .touch_reg(touch_reg),
        .load_vld(load_vld), .load_id(pend_q),
        .cur_vld(cur_vld), .cur_reg(cur_reg)
    );

    cop_sched_fifo #(.DEPTH(QDEPTH), .W(ID_W)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data(sel_id), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    cop_bs_lut #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_lut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_id(cfg_id), .wr_addr(cfg_addr), .wr_len(cfg_len),
        .rd_id(q_head), .rd_addr(xfer_addr), .rd_len(xfer_len)
    );

    // Table and buffer controls decoded from the sequencer state
    always_comb begin
        q_push    = (state_q == ST_IDLE) && sel_req && !hit && !q_full;
        q_pop     = (state_q == ST_ISSUE) && !q_empty;
        touch_vld = 1'b0;
        touch_reg = hit_reg;
        load_vld  = 1'b0;
        if (state_q == ST_IDLE && sel_req && hit) begin
            touch_vld = 1'b1;
        end else if (state_q == ST_WAIT && xfer_done) begin
            touch_vld = 1'b1;
            touch_reg = vic_q;
            load_vld  = 1'b1;
        end
    end

    // Request sequencer: lookup, issue, wait for transfer, hold acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (sel_req && hit) state_q <= ST_HOLD;
                          else if (q_push)    state_q <= ST_ISSUE;
                ST_ISSUE: if (q_pop)          state_q <= ST_WAIT;
                ST_WAIT:  if (xfer_done)      state_q <= ST_HOLD;
                ST_HOLD:  if (!sel_req)       state_q <= ST_IDLE;
                default:                      state_q <= ST_IDLE;
            endcase
        end
    end

    // Region chosen for the pending load, latched when the miss is taken
    always_ff @(posedge clk) begin
        if (!rst_n)      vic_q <= '0;
        else if (q_push) vic_q <= victim_reg;
    end

    // Identifier being transferred, latched as it leaves the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= '0;
        else if (q_pop) pend_q <= q_head;
    end

    assign sel_ack     = (state_q == ST_HOLD);
    assign sel_region  = cur_reg;
    assign xfer_start  = q_pop;
    assign xfer_region = vic_q;
endmodule

// File: rtl/cop_reload_chk.sv
// Protocol checker for the reconfiguration request controller, bound to
// the top. Observes ports and the region-in-use state.
// Assumes: the environment keeps sel_req high until acknowledged.
module cop_reload_chk #(
    parameter int NUM_REGIONS = 2,
    localparam int RW         = cop_pkg::region_w(NUM_REGIONS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_req,
    input logic          sel_ack,
    input logic          xfer_start,
    input logic [RW-1:0] xfer_region,
    input logic          cur_vld,
    input logic [RW-1:0] cur_reg
);
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ack && sel_req) |=> sel_ack); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ack && !sel_req) |=> !sel_ack); // R5
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ack) |-> $past(sel_req)); // R2
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R3
    AST_NO_ACK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !sel_ack); // R4
    AST_VICTIM_NOT_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && cur_vld) |-> (xfer_region != cur_reg)); // R8
    AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (int'(xfer_region) < NUM_REGIONS)); // R6
endmodule

bind cop_reload_ctrl cop_reload_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_ack(sel_ack),
    .xfer_start(xfer_start), .xfer_region(xfer_region),
    .cur_vld(cur_vld), .cur_reg(cur_reg)
);

// File: tb/cop_reload_ctrl_tb.sv
// Self-checking bench: three regions, directed replacement cases followed
// by a pseudo-random sweep, checked against a last-use-stamp model.
module cop_reload_ctrl_tb;
    localparam int NR = 3;
    localparam int IW = 4;
    localparam int AW = 16;
    localparam int LW = 12;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_req = 1'b0;
    logic [IW-1:0] sel_id = '0;
    logic          sel_ack;
    logic [RW-1:0] sel_region;
    logic          dis_req = 1'b0;
    logic [IW-1:0] dis_id = '0;
    logic          cfg_wr = 1'b0;
    logic [IW-1:0] cfg_id = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          xfer_start;
    logic [RW-1:0] xfer_region;
    logic [AW-1:0] xfer_addr;
    logic [LW-1:0] xfer_len;
    logic          xfer_done = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Model state
    int m_vld [NR];
    int m_dis [NR];
    int m_id  [NR];
    int m_ts  [NR];
    int m_cur = -1;
    int tick = 0;
    int lut_a [16];
    int lut_l [16];

    cop_reload_ctrl #(.NUM_REGIONS(NR), .ID_W(IW), .ADDR_W(AW), .LEN_W(LW), .QDEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_id(sel_id),
        .sel_ack(sel_ack), .sel_region(sel_region),
        .dis_req(dis_req), .dis_id(dis_id),
        .cfg_wr(cfg_wr), .cfg_id(cfg_id), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .xfer_start(xfer_start), .xfer_region(xfer_region),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic host_write(input int id, input int a, input int l);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_id = IW'(id); cfg_addr = AW'(a); cfg_len = LW'(l);
        @(negedge clk);
        cfg_wr = 1'b0;
        lut_a[id] = a;
        lut_l[id] = l;
    endtask

    task automatic dismiss(input int id);
        @(negedge clk);
        dis_req = 1'b1; dis_id = IW'(id);
        @(negedge clk);
        dis_req = 1'b0;
        for (int j = 0; j < NR; j++)
            if (m_vld[j] != 0 && m_id[j] == id) m_dis[j] = 1;
    endtask

    // Model lookup and replacement choice; rule gives the requirement tag
    task automatic predict(input int id, output int hj, output int vj, output string rule);
        hj = -1; vj = -1; rule = "R8";
        for (int j = NR - 1; j >= 0; j--)
            if (m_vld[j] != 0 && m_id[j] == id) hj = j;
        for (int j = NR - 1; j >= 0; j--)
            if (j != m_cur && m_vld[j] == 0) begin vj = j; rule = "R6"; end
        if (vj < 0)
            for (int j = NR - 1; j >= 0; j--)
                if (j != m_cur && m_dis[j] != 0) begin vj = j; rule = "R7"; end
        if (vj < 0) begin
            int best = 0;
            for (int j = 0; j < NR; j++)
                if (j != m_cur && (vj < 0 || m_ts[j] < best)) begin vj = j; best = m_ts[j]; end
        end
    endtask

    task automatic do_select(input int id, input int dly, input string vtag);
        int hj, vj;
        string rule;
        predict(id, hj, vj, rule);
        if (vtag != "") rule = vtag;
        @(negedge clk);
        sel_req = 1'b1; sel_id = IW'(id);
        @(negedge clk);
        if (hj >= 0) begin
            chk(sel_ack == 1'b1, "R2", "hit ack", int'(sel_ack), 1);
            chk(xfer_start == 1'b0, "R2", "hit no start", int'(xfer_start), 0);
            chk(int'(sel_region) == hj, "R2", "hit region", int'(sel_region), hj);
            m_dis[hj] = 0; m_ts[hj] = ++tick; m_cur = hj;
        end else begin
            chk(sel_ack == 1'b0, "R4", "miss early ack", int'(sel_ack), 0);
            chk(xfer_start == 1'b1, "R3", "miss start", int'(xfer_start), 1);
            chk(int'(xfer_region) == vj, rule, "victim region", int'(xfer_region), vj);
            chk(int'(xfer_addr) == lut_a[id], "R10", "xfer addr", int'(xfer_addr), lut_a[id]);
            chk(int'(xfer_len) == lut_l[id], "R3", "xfer len", int'(xfer_len), lut_l[id]);
            @(negedge clk);
            chk(xfer_start == 1'b0, "R3", "start single", int'(xfer_start), 0);
            for (int k = 0; k < dly; k++) begin
                chk(sel_ack == 1'b0, "R4", "ack before done", int'(sel_ack), 0);
                @(negedge clk);
            end
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            chk(sel_ack == 1'b1, "R4", "ack after done", int'(sel_ack), 1);
            chk(int'(sel_region) == vj, "R4", "loaded region", int'(sel_region), vj);
            m_vld[vj] = 1; m_id[vj] = id; m_dis[vj] = 0; m_ts[vj] = ++tick; m_cur = vj;
        end
        @(negedge clk);
        chk(sel_ack == 1'b1, "R5", "ack held", int'(sel_ack), 1);
        sel_req = 1'b0;
        @(negedge clk);
        chk(sel_ack == 1'b0, "R5", "ack released", int'(sel_ack), 0);
    endtask

    initial begin
        logic [15:0] lf;
        for (int j = 0; j < NR; j++) begin m_vld[j] = 0; m_dis[j] = 0; m_id[j] = 0; m_ts[j] = 0; end
        for (int i = 0; i < 16; i++) begin lut_a[i] = 0; lut_l[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel_ack == 1'b0, "R1", "reset ack", int'(sel_ack), 0);
        chk(xfer_start == 1'b0, "R1", "reset start", int'(xfer_start), 0);
        for (int i = 0; i < 16; i++) host_write(i, 16'h0100 * i + 16'h0010, i + 3);

        // Fill: empty regions taken in order (R1 first miss, R6)
        do_select(1, 2, "R1");
        do_select(2, 0, "R6");
        do_select(3, 1, "R6");
        // R11: dismissal cleared by a later hit
        dismiss(1);
        do_select(2, 0, "");
        do_select(1, 0, "");
        do_select(3, 0, "");
        do_select(4, 1, "R11");
        // R7: dismissed region wins over older one
        dismiss(3);
        do_select(5, 2, "R7");
        // R9: dismiss of non-resident identifier has no effect
        dismiss(12);
        do_select(6, 0, "R9");
        // R10: rewritten lookup entry used by the next load
        host_write(9, 16'hBEEF, 77);
        do_select(9, 3, "");
        do_select(15, 1, "");

        // Pseudo-random sweep
        lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[1:0] == 2'd0) dismiss(int'(lf[7:4]) % 6);
            else do_select(int'(lf[11:8]) % 6, int'(lf[3:2]), "");
        end
        finish_run();
    end
endmodule